// File: doc/BRIEF.md
# Display-Memory I2C Target with 14-bit Auto-Incrementing Pointer

This block lets a host microcontroller reach the internal 16 KB address space of an on-screen display engine over a two-wire I2C bus. SCL and SDA are oversampled in the system clock domain. The block detects START and STOP, answers only to its own 7-bit device address, and takes a 14-bit byte pointer sent low byte first. It then moves data bytes between the bus and the internal space, and the pointer advances by one after every byte.

The sixteen control registers live inside the block and are presented in parallel to the display pipeline. Display RAM and the character ROM are outside the block and are reached through a simple strobe-based memory port, with read data returned one cycle after the strobe. Reads use two transactions. The first is a write-direction transaction that only sets the pointer. The second is a read-direction transaction that streams bytes from that pointer until the host declines one. The display RAM may be updated this way at any time, including while a page is shown.

Top module: `i2c_osd_slave`

## Requirements
- R1: The address bytes 0xBA (write) and 0xBB (read), which carry device address 0x5D, are acknowledged by SDA low during the ninth clock. Any other address byte is left unacknowledged and the block stays silent until the next START.
- R2: In a write transaction, the first byte after the address is pointer bits 7..0. The second is pointer bits 13..8 in its low six bits, and its two top bits are ignored. Every later byte is stored at the pointer and acknowledged.
- R3: The pointer increments by one after each data byte, in writes and in reads.
- R4: A read transaction returns bytes starting at the current pointer. The pointer survives STOP, so a read that follows a write without setting the pointer starts just past the last byte written.
- R5: After reset, control register k (address 0x3FF0+k, presented on `cfg_regs[8k+7:8k]`) holds 0x3F for k=0, 0x08 for k=1, 0x12 for k=2, 0x28 for k=6, 0x0A for k=7 and 0x00 for every other k.
- R6: All sixteen control registers can be written and read back over I2C, and a written value appears on `cfg_regs`.
- R7: Reads in 0x2000..0x32FF come from the memory port. Writes there are acknowledged and produce no write strobe.
- R8: Reads from unmapped addresses (0x0400..0x1FFF, 0x3300..0x3FEF) return 0x00. Writes there are acknowledged and discarded.
- R9: When the host answers a read byte with NACK, the block releases SDA and does not drive it again until a new START.
- R10: A START in the middle of a transaction (repeated START) restarts the address phase without a STOP, and the pointer is kept.
- R11: `mem_wr` pulses for exactly one cycle, only for addresses 0x0000..0x03FF, and never together with `mem_rd`. `mem_rd` is raised only for RAM or ROM addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| mem_addr | output | 14 | Byte address on the memory port |
| mem_wr | output | 1 | One-cycle write strobe for display RAM |
| mem_wdata | output | 8 | Write data |
| mem_rd | output | 1 | One-cycle read strobe for RAM or ROM |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| cfg_regs | output | 128 | Control registers, register k at bits 8k+7..8k |

## Verification
The assertions assume that each SCL phase spans many system clocks, so that every line change passes the synchronizer before the next SCL edge. They also assume that the host moves SDA only while SCL is low, except when it forms START or STOP. The bench holds each quarter bit for fifteen clocks and sequences its tasks to respect both rules. The RAM model answers `mem_rd` in the following cycle, which is the only latency the capture logic allows for.

// File: rtl/i2c_osd_pkg.sv
package i2c_osd_pkg;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEV,
        PH_PLO,
        PH_PHI,
        PH_WDAT,
        PH_ACK,
        PH_RDAT,
        PH_RACK
    } phase_e;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_RAM,
        RG_ROM,
        RG_CTRL
    } region_e;

    // Power-up contents of the control register bank, by index.
    function automatic logic [7:0] ctrl_reset(input int unsigned idx);
        case (idx)
            0:       return 8'h3F;
            1:       return 8'h08;
            2:       return 8'h12;
            6:       return 8'h28;
            7:       return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_osd_linesync.sv
module i2c_osd_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PW = STAGES + 1;

    typedef struct packed {
        logic [PW-1:0] scl;
        logic [PW-1:0] sda;
    } pipe_t;

    pipe_t d, q;

    always_comb begin
        d.scl = {q.scl[PW-2:0], scl_i};
        d.sda = {q.sda[PW-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    logic scl_prev, sda_prev;
    assign scl_s    = q.scl[STAGES-1];
    assign sda_s    = q.sda[STAGES-1];
    assign scl_prev = q.scl[STAGES];
    assign sda_prev = q.sda[STAGES];

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_osd_ctrlregs.sv
module i2c_osd_ctrlregs
    import i2c_osd_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int RIW = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [RIW-1:0]     widx,
    input  logic [DW-1:0]      wdata,
    output logic [NREG*DW-1:0] regs_flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (we && widx == RIW'(i)) val_d = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= DW'(ctrl_reset(i));
            else        val_q <= val_d;
        end

        assign regs_flat[i*DW +: DW] = val_q;
    end
endmodule

// File: rtl/i2c_osd_slave.sv
module i2c_osd_slave
    import i2c_osd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h5D,
    parameter int         AW          = 14,
    parameter int         DW          = 8,
    parameter int         NREG        = 16,
    parameter int         RAM_BASE    = 'h0000,
    parameter int         RAM_BYTES   = 'h0400,
    parameter int         ROM_BASE    = 'h2000,
    parameter int         ROM_BYTES   = 'h1300,
    parameter int         REG_BASE    = 'h3FF0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [AW-1:0]      mem_addr,
    output logic               mem_wr,
    output logic [DW-1:0]      mem_wdata,
    output logic               mem_rd,
    input  logic [DW-1:0]      mem_rdata,
    output logic [NREG*DW-1:0] cfg_regs
);
    localparam int          CW      = $clog2(DW + 1);
    localparam int          RIW     = $clog2(NREG);
    localparam int          HI_W    = AW - DW;
    localparam logic [31:0] RAM_LO  = 32'(RAM_BASE);
    localparam logic [31:0] RAM_HI  = 32'(RAM_BASE + RAM_BYTES);
    localparam logic [31:0] ROM_LO  = 32'(ROM_BASE);
    localparam logic [31:0] ROM_HI  = 32'(ROM_BASE + ROM_BYTES);
    localparam logic [31:0] REG_LO  = 32'(REG_BASE);
    localparam logic [31:0] REG_HI  = 32'(REG_BASE + NREG);

    function automatic region_e region_of(input logic [AW-1:0] a);
        logic [31:0] v;
        v = 32'(a);
        if (v >= RAM_LO && v < RAM_HI) return RG_RAM;
        if (v >= ROM_LO && v < ROM_HI) return RG_ROM;
        if (v >= REG_LO && v < REG_HI) return RG_CTRL;
        return RG_NONE;
    endfunction

    typedef struct packed {
        phase_e        ph;
        phase_e        nxt;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic [AW-1:0] ptr;
        logic          oe;
        logic          fetch;
        logic          cap;
        region_e       src;
        logic [DW-1:0] rbuf;
        logic          hack;
    } state_t;

    state_t d, q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_osd_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    logic          wr_evt;
    logic          reg_we;
    logic [DW-1:0] reg_rd;
    logic [DW-1:0] reg_arr [NREG];

    i2c_osd_ctrlregs #(.NREG(NREG), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .widx      (q.ptr[RIW-1:0]),
        .wdata     (q.sh),
        .regs_flat (cfg_regs)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_view
        assign reg_arr[i] = cfg_regs[i*DW +: DW];
    end
    assign reg_rd = reg_arr[q.ptr[RIW-1:0]];

    // Next-state computation
    always_comb begin
        d      = q;
        d.fetch = 1'b0;
        d.cap   = q.fetch;
        wr_evt  = 1'b0;

        if (q.cap) begin
            case (q.src)
                RG_RAM, RG_ROM: d.rbuf = mem_rdata;
                RG_CTRL:        d.rbuf = reg_rd;
                default:        d.rbuf = '0;
            endcase
        end

        if (stop_det) begin
            d.ph = PH_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.ph  = PH_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            case (q.ph)
                PH_DEV, PH_PLO, PH_PHI, PH_WDAT: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[DW-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CW'(DW)) begin
                        d.cnt = '0;
                        d.oe  = 1'b1;
                        d.ph  = PH_ACK;
                        case (q.ph)
                            PH_DEV: begin
                                if (q.sh[DW-1:1] == DEV_ADDR) begin
                                    if (q.sh[0]) begin
                                        d.nxt   = PH_RDAT;
                                        d.fetch = 1'b1;
                                        d.src   = region_of(q.ptr);
                                    end else begin
                                        d.nxt = PH_PLO;
                                    end
                                end else begin
                                    d.oe = 1'b0;
                                    d.ph = PH_IDLE;
                                end
                            end
                            PH_PLO: begin
                                d.ptr[DW-1:0] = q.sh;
                                d.nxt         = PH_PHI;
                            end
                            PH_PHI: begin
                                d.ptr[AW-1:DW] = q.sh[HI_W-1:0];
                                d.nxt          = PH_WDAT;
                            end
                            default: begin
                                wr_evt = 1'b1;
                                d.ptr  = q.ptr + 1'b1;
                                d.nxt  = PH_WDAT;
                            end
                        endcase
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.nxt == PH_RDAT) begin
                            d.ph = PH_RDAT;
                            d.sh = q.rbuf;
                            d.oe = ~q.rbuf[DW-1];
                        end else begin
                            d.ph = q.nxt;
                            d.oe = 1'b0;
                        end
                    end
                end
                PH_RDAT: begin
                    if (scl_fall) begin
                        if (q.cnt == CW'(DW - 1)) begin
                            d.oe    = 1'b0;
                            d.ph    = PH_RACK;
                            d.cnt   = '0;
                            d.ptr   = q.ptr + 1'b1;
                            d.fetch = 1'b1;
                            d.src   = region_of(q.ptr + 1'b1);
                        end else begin
                            d.sh  = {q.sh[DW-2:0], 1'b0};
                            d.oe  = ~q.sh[DW-2];
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_rise) begin
                        d.hack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.hack) begin
                            d.ph  = PH_RDAT;
                            d.sh  = q.rbuf;
                            d.oe  = ~q.rbuf[DW-1];
                            d.cnt = '0;
                        end else begin
                            d.ph = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
            q.nxt  <= PH_IDLE;
            q.src  <= RG_NONE;
        end else begin
            q <= d;
        end
    end

    region_e cur_region;
    assign cur_region = region_of(q.ptr);
    assign reg_we     = wr_evt && (cur_region == RG_CTRL);
    assign mem_wr     = wr_evt && (cur_region == RG_RAM);
    assign mem_rd     = q.fetch && (q.src == RG_RAM || q.src == RG_ROM);
    assign mem_addr   = q.ptr;
    assign mem_wdata  = q.sh;
    assign sda_oe     = q.oe;
endmodule

// File: rtl/i2c_osd_slave_chk.sv
module i2c_osd_slave_chk #(
    parameter int AW       = 14,
    parameter int RAM_END  = 'h0400,
    parameter int ROM_LO   = 'h2000,
    parameter int ROM_END  = 'h3300
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe,
    input logic          mem_wr,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr
);
    // R11: RAM is the only writable memory target
    a_r11_wr_only_ram: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (32'(mem_addr) < 32'(RAM_END)));

    // R7 / R11: reads reach the port only for RAM or ROM
    a_r7_rd_only_mapped: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (32'(mem_addr) < 32'(RAM_END) ||
                    (32'(mem_addr) >= 32'(ROM_LO) && 32'(mem_addr) < 32'(ROM_END))));

    // R11: strobes are exclusive
    a_r11_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    // R11: write strobe lasts one cycle
    a_r11_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    // R1: SDA is only taken while the clock line is low
    a_r1_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);
endmodule

bind i2c_osd_slave i2c_osd_slave_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .mem_wr   (mem_wr),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr)
);

// File: tb/test_i2c_osd_slave.sv
module test_i2c_osd_slave;
    localparam int Q = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         m_scl = 1'b1;
    logic         m_sda_low = 1'b0;
    logic         sda_oe;
    logic [13:0]  mem_addr;
    logic         mem_wr, mem_rd;
    logic [7:0]   mem_wdata;
    logic [7:0]   mem_rdata = 8'h00;
    logic [127:0] cfg_regs;
    logic         sda_line;

    assign sda_line = !(m_sda_low || sda_oe);

    always #5 clk = ~clk;

    i2c_osd_slave i_i2c_osd_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .cfg_regs  (cfg_regs)
    );

    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;
    logic [7:0] ram [1024];
    logic [7:0] wbuf [16];
    logic [7:0] rbuf [16];

    function automatic logic [7:0] rom_val(input logic [13:0] a);
        return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] reset_exp(input int k);
        case (k)
            0: return 8'h3F;
            1: return 8'h08;
            2: return 8'h12;
            6: return 8'h28;
            7: return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (mem_wr) begin
            ram[mem_addr[9:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (mem_rd)
            mem_rdata <= (mem_addr < 14'h0400) ? ram[mem_addr[9:0]] : rom_val(mem_addr);
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n * Q) @(posedge clk);
    endtask

    task automatic i2c_start();
        m_sda_low = 1'b0; qw(1);
        m_scl = 1'b1; qw(2);
        m_sda_low = 1'b1; qw(2);
        m_scl = 1'b0; qw(1);
    endtask

    task automatic i2c_stop();
        m_sda_low = 1'b1; qw(1);
        m_scl = 1'b1; qw(2);
        m_sda_low = 1'b0; qw(2);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; qw(1);
            m_scl = 1'b1; qw(2);
            m_scl = 1'b0; qw(1);
        end
        m_sda_low = 1'b0; qw(1);
        m_scl = 1'b1; qw(1);
        ack = !sda_line; qw(1);
        m_scl = 1'b0; qw(1);
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] v);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            qw(1);
            m_scl = 1'b1; qw(1);
            v[i] = sda_line; qw(1);
            m_scl = 1'b0; qw(1);
        end
        m_sda_low = give_ack; qw(1);
        m_scl = 1'b1; qw(2);
        m_scl = 1'b0; qw(1);
        m_sda_low = 1'b0;
    endtask

    task automatic send_ptr(input logic [13:0] a, input string tag);
        logic ack;
        i2c_start();
        wbyte(8'hBA, ack);           chk({tag, " R1 addr ack"}, {7'd0, ack}, 8'h01);
        wbyte(a[7:0], ack);          chk({tag, " R2 ptr lo ack"}, {7'd0, ack}, 8'h01);
        wbyte({2'b11, a[13:8]}, ack); chk({tag, " R2 ptr hi ack"}, {7'd0, ack}, 8'h01);
    endtask

    task automatic wr_seq(input logic [13:0] a, input int n, input string tag);
        logic ack;
        send_ptr(a, tag);
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], ack);
            chk({tag, " data ack"}, {7'd0, ack}, 8'h01);
        end
        i2c_stop();
    endtask

    task automatic rd_cur(input int n, input string tag);
        logic ack;
        i2c_start();
        wbyte(8'hBB, ack);
        chk({tag, " R1 read addr ack"}, {7'd0, ack}, 8'h01);
        for (int i = 0; i < n; i++) rbyte(i != n - 1, rbuf[i]);
        i2c_stop();
    endtask

    task automatic rd_seq(input logic [13:0] a, input int n, input string tag);
        send_ptr(a, tag);
        i2c_stop();
        rd_cur(n, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base_wr;
        logic ack;
        logic [7:0] v;
        repeat (10) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5: reset state on the parallel port, bus released
        for (int k = 0; k < 16; k++) chk("R5 reset cfg_regs", cfg_regs[k*8 +: 8], reset_exp(k));
        chk("R9 sda released at reset", {7'd0, sda_oe}, 8'h00);

        // R1: foreign addresses are ignored
        i2c_start();
        wbyte(8'hA4, ack); chk("R1 foreign addr nack", {7'd0, ack}, 8'h00);
        i2c_stop();
        i2c_start();
        wbyte(8'hBC, ack); chk("R1 near addr nack", {7'd0, ack}, 8'h00);
        wbyte(8'h00, ack); chk("R1 silent after nack", {7'd0, ack}, 8'h00);
        i2c_stop();

        // R5: reset values read over the bus
        rd_seq(14'h3FF0, 16, "R5");
        for (int k = 0; k < 16; k++) chk("R5 reset read", rbuf[k], reset_exp(k));

        // R6: register sweep
        for (int k = 0; k < 16; k++) wbuf[k] = 8'(k * 37 + 5);
        wr_seq(14'h3FF0, 16, "R6");
        repeat (4) @(negedge clk);
        for (int k = 0; k < 16; k++) chk("R6 cfg_regs after write", cfg_regs[k*8 +: 8], 8'(k * 37 + 5));
        rd_seq(14'h3FF0, 16, "R6");
        for (int k = 0; k < 16; k++) chk("R6 reg readback", rbuf[k], 8'(k * 37 + 5));

        // R2 / R3: RAM burst write and read back
        base_wr = wr_cnt;
        for (int k = 0; k < 8; k++) wbuf[k] = 8'(k * 29 + 1);
        wr_seq(14'h0123, 8, "R2");
        chk("R3 RAM write strobes", 8'(wr_cnt - base_wr), 8'd8);
        for (int k = 0; k < 8; k++) chk("R2 R3 RAM content", ram[10'h123 + 10'(k)], 8'(k * 29 + 1));
        rd_seq(14'h0123, 8, "R3");
        for (int k = 0; k < 8; k++) chk("R3 RAM read increment", rbuf[k], 8'(k * 29 + 1));

        // R4: pointer kept across STOP
        wbuf[0] = 8'h77; wbuf[1] = 8'h99;
        wr_seq(14'h0200, 2, "R4");
        wbuf[0] = 8'h55;
        wr_seq(14'h0200, 1, "R4");
        rd_cur(1, "R4");
        chk("R4 read after write continues", rbuf[0], 8'h99);

        // R7: ROM region reads, writes discarded
        rd_seq(14'h2FFE, 4, "R7");
        for (int k = 0; k < 4; k++) chk("R7 ROM read", rbuf[k], rom_val(14'h2FFE + 14'(k)));
        base_wr = wr_cnt;
        wbuf[0] = 8'h00; wbuf[1] = 8'hFF;
        wr_seq(14'h2000, 2, "R7");
        chk("R7/R11 ROM write no strobe", 8'(wr_cnt - base_wr), 8'd0);
        rd_seq(14'h2000, 2, "R7");
        chk("R7 ROM unchanged 0", rbuf[0], rom_val(14'h2000));
        chk("R7 ROM unchanged 1", rbuf[1], rom_val(14'h2001));

        // R8: boundaries into empty space
        rd_seq(14'h32FE, 3, "R8");
        chk("R8 ROM last-1", rbuf[0], rom_val(14'h32FE));
        chk("R8 ROM last", rbuf[1], rom_val(14'h32FF));
        chk("R8 past ROM", rbuf[2], 8'h00);
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2;
        wr_seq(14'h03FE, 2, "R8");
        rd_seq(14'h03FE, 3, "R8");
        chk("R8 RAM end-1", rbuf[0], 8'hA1);
        chk("R8 RAM end", rbuf[1], 8'hA2);
        chk("R8 past RAM", rbuf[2], 8'h00);
        rd_seq(14'h1000, 2, "R8");
        chk("R8 gap read 0", rbuf[0], 8'h00);
        chk("R8 gap read 1", rbuf[1], 8'h00);
        base_wr = wr_cnt;
        wbuf[0] = 8'h3C; wbuf[1] = 8'hC3;
        wr_seq(14'h0400, 2, "R8");
        chk("R8 gap write no strobe", 8'(wr_cnt - base_wr), 8'd0);
        rd_seq(14'h0400, 1, "R8");
        chk("R8 gap still zero", rbuf[0], 8'h00);
        repeat (2) @(negedge clk);
        chk("R8 regs untouched by gap write", cfg_regs[7:0], 8'(5));

        // R9: NACK releases the line until a START
        send_ptr(14'h0123, "R9");
        i2c_stop();
        i2c_start();
        wbyte(8'hBB, ack);
        rbyte(1'b0, v);
        chk("R9 byte before nack", v, 8'd1);
        begin
            int held = 0;
            for (int i = 0; i < 18; i++) begin
                qw(1);
                m_scl = 1'b1; qw(1);
                if (!sda_line) held++;
                qw(1);
                m_scl = 1'b0; qw(1);
            end
            chk("R9 sda released after nack", 8'(held), 8'd0);
        end
        i2c_stop();

        // R10: repeated START switches direction without STOP
        send_ptr(14'h0124, "R10");
        i2c_start();
        wbyte(8'hBB, ack);
        chk("R10 read addr ack after rstart", {7'd0, ack}, 8'h01);
        rbyte(1'b1, v);
        chk("R10 first byte", v, 8'd30);
        rbyte(1'b0, v);
        chk("R10 second byte", v, 8'd59);
        i2c_stop();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule